// File: doc/BRIEF.md
# Serial Readback Ping-Pong Capture

This block reads back a device's configuration memory as one long serial bit stream and packs it into two alternating 128-bit holding registers. While one register fills from the serial line, a processor reads the other over a narrow parallel port as eight 16-bit words. When it has finished with that register, the processor acknowledges it, which frees the register for the next fill.

The block drives the readback bit clock itself, from a half-period divider of the system clock. Only settings that keep the bit rate between 1 and 2 Mbit/s are taken. A pass begins only when software issues a start command, with a total bit count for the frame. The pass runs until that many bits have been taken. At the end a done pulse is raised, and a partly filled final register is handed over as full.

If a register completes a second time before the processor has acknowledged it, a sticky overrun flag is raised. The register's data is overwritten in either case. The block does not inspect the captured data.

Top module: `rb_pingpong_capture`

## Requirements
- R1: After reset, busy, rb_clk, done, cfg_err and overrun are 0, full is 2'b00, and rd_data reads 0 for every buffer and word address.
- R2: When the block is idle, a start pulse is accepted only if div_half lies in 25..50 (system clock 100 MHz) and frame_bits is nonzero. An accepted start sets busy and clears cfg_err. A refused start sets cfg_err, leaves busy at 0 and produces no rb_clk edges. A start pulse while busy has no effect.
- R3: While busy, rb_clk has a period of exactly 2*div_half system clocks, using the div_half value latched at the accepted start. Later changes to div_half do not alter it.
- R4: rb_clk is low whenever the block is idle. Each bit is taken from rb_data at the system clock edge where rb_clk falls, so the device may change rb_data once rb_clk is low.
- R5: The n-th bit of a register fill (n = 0..127) is stored at bit position n of that register. Fills alternate between buffer 0 and buffer 1, and every pass starts with buffer 0. full[b] sets at the edge that stores the 128th bit of buffer b. With rd_sel = b and rd_addr = w, rd_data shows bits 16w+15 down to 16w of buffer b in the same cycle.
- R6: A one-cycle pulse on ack[b] clears full[b]. If buffer b completes while full[b] is still set and ack[b] is not asserted in that cycle, overrun sets. The new data replaces the old in either case. overrun stays set until the next accepted start.
- R7: After frame_bits bits have been taken, busy falls and done is high for exactly one cycle. The register in use at that point is marked full, and its positions beyond the last bit taken read 0.
- R8: Reading the other buffer and acknowledging it during a fill do not change the bits captured into the buffer that is filling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start command pulse |
| div_half | input | 8 | Bit clock half period in system clocks |
| frame_bits | input | 32 | Total number of bits in the pass |
| rb_data | input | 1 | Serial readback data from the device |
| rb_clk | output | 1 | Readback bit clock to the device |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse after the last bit |
| cfg_err | output | 1 | Last start refused for an illegal setting |
| full | output | 2 | Per-buffer full flags |
| overrun | output | 1 | Sticky overrun flag |
| ack | input | 2 | Per-buffer read acknowledge pulses |
| rd_sel | input | 1 | Buffer selected for reading |
| rd_addr | input | 3 | Word address within the selected buffer |
| rd_data | output | 16 | Selected 16-bit word |

## Verification
The effect of an accepted or refused start shows up at the system clock edge that takes the pulse. The bench drives the pulse at a falling system clock edge and looks at busy and cfg_err at the next falling edge. With a latched divider H, rb_clk first rises H edges after acceptance, and bit k is taken 2H(k+1) edges after acceptance. full, done and the busy drop appear right after that capturing edge, and an ack clears its flag at the following edge. The bench therefore polls these flags only at falling system edges, and it changes rb_data one system clock after each falling rb_clk edge. It times the divider by counting falling system edges between successive rb_clk rises. rd_data has no register in its path, so the bench samples it one time unit after it sets rd_sel and rd_addr.

// File: rtl/rbk_pkg.sv
package rbk_pkg;
   localparam int unsigned NBUF = 2;

   function automatic logic in_window(input int unsigned v,
                                      input int unsigned lo,
                                      input int unsigned hi);
      return (v >= lo) && (v <= hi);
   endfunction
endpackage

// File: rtl/rbk_bitclk.sv
module rbk_bitclk #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half,
   output logic             rb_clk,
   output logic             sample
);
   logic [DIV_W-1:0] cnt_q;
   logic             wrap;

   assign wrap   = (cnt_q == half - DIV_W'(1));
   assign sample = run && wrap && rb_clk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         rb_clk <= 1'b0;
      end else if (!run) begin
         cnt_q  <= '0;
         rb_clk <= 1'b0;
      end else if (wrap) begin
         cnt_q  <= '0;
         rb_clk <= ~rb_clk;
      end else begin
         cnt_q  <= cnt_q + DIV_W'(1);
      end
   end

   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !rb_clk); // R4
endmodule

// File: rtl/rbk_ctrl.sv
module rbk_ctrl
   import rbk_pkg::*;
#(
   parameter int DIV_W    = 8,
   parameter int CNT_W    = 32,
   parameter int BUF_W    = 128,
   parameter int HALF_MIN = 25,
   parameter int HALF_MAX = 50,
   localparam int IDX_W   = $clog2(BUF_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DIV_W-1:0] div_half,
   input  logic [CNT_W-1:0] frame_bits,
   input  logic             sample,
   input  logic [NBUF-1:0]  ack,
   output logic             busy,
   output logic [DIV_W-1:0] half_q,
   output logic             wr_en,
   output logic             wr_sel,
   output logic [IDX_W-1:0] wr_idx,
   output logic             done,
   output logic             cfg_err,
   output logic [NBUF-1:0]  full,
   output logic             overrun
);
   logic [CNT_W-1:0] total_q, got_q;
   logic [IDX_W-1:0] idx_q;
   logic             sel_q;
   logic             cfg_ok, accept, refuse;
   logic             end_of_buf, end_of_frame, close_buf;

   assign cfg_ok       = in_window(int'(div_half), HALF_MIN, HALF_MAX) && (frame_bits != '0);
   assign accept       = start && !busy && cfg_ok;
   assign refuse       = start && !busy && !cfg_ok;
   assign end_of_buf   = (idx_q == IDX_W'(BUF_W - 1));
   assign end_of_frame = ((got_q + CNT_W'(1)) == total_q);
   assign close_buf    = sample && (end_of_buf || end_of_frame);

   assign wr_en  = sample;
   assign wr_sel = sel_q;
   assign wr_idx = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         half_q  <= DIV_W'(HALF_MAX);
         total_q <= '0;
         got_q   <= '0;
         idx_q   <= '0;
         sel_q   <= 1'b0;
         done    <= 1'b0;
         cfg_err <= 1'b0;
         full    <= '0;
         overrun <= 1'b0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            busy    <= 1'b1;
            half_q  <= div_half;
            total_q <= frame_bits;
            got_q   <= '0;
            idx_q   <= '0;
            sel_q   <= 1'b0;
            full    <= '0;
            overrun <= 1'b0;
            cfg_err <= 1'b0;
         end else begin
            if (refuse) cfg_err <= 1'b1;
            for (int b = 0; b < NBUF; b++) begin
               if (ack[b]) full[b] <= 1'b0;
            end
            if (sample) begin
               got_q <= got_q + CNT_W'(1);
               idx_q <= close_buf ? '0 : idx_q + IDX_W'(1);
               if (close_buf) begin
                  full[sel_q] <= 1'b1;
                  if (full[sel_q] && !ack[sel_q]) overrun <= 1'b1;
                  sel_q <= ~sel_q;
               end
               if (end_of_frame) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end
            end
         end
      end
   end

   AST_RUN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (int'(half_q) >= HALF_MIN && int'(half_q) <= HALF_MAX)); // R3
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !start) |=> overrun); // R6

   for (genvar b = 0; b < NBUF; b++) begin : g_chk
      AST_FULL_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(full[b]) |-> $past(sample)); // R5
   end
endmodule

// File: rtl/rbk_bank.sv
module rbk_bank
   import rbk_pkg::*;
#(
   parameter int BUF_W    = 128,
   parameter int WORD_W   = 16,
   parameter int RD_REG   = 0,
   localparam int IDX_W   = $clog2(BUF_W),
   localparam int WORDS   = BUF_W / WORD_W,
   localparam int ADDR_W  = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_bit,
   input  logic              rd_sel,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data
);
   logic [BUF_W-1:0]  bufs [NBUF];
   logic [WORD_W-1:0] word_c;

   for (genvar b = 0; b < NBUF; b++) begin : g_buf
      logic [BUF_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (wr_en && (wr_sel == 1'(b))) begin
            if (wr_idx == '0) begin
               q    <= '0;
               q[0] <= wr_bit;
            end else begin
               q[wr_idx] <= wr_bit;
            end
         end
      end
      assign bufs[b] = q;
   end

   assign word_c = bufs[rd_sel][int'(rd_addr) * WORD_W +: WORD_W];

   if (RD_REG == 0) begin : g_rd_comb
      assign rd_data = word_c;
   end else begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= word_c;
      end
   end
endmodule

// File: rtl/rb_pingpong_capture.sv
module rb_pingpong_capture
   import rbk_pkg::*;
#(
   parameter int SYS_HZ   = 100_000_000,
   parameter int RATE_MIN = 1_000_000,
   parameter int RATE_MAX = 2_000_000,
   parameter int DIV_W    = 8,
   parameter int CNT_W    = 32,
   parameter int BUF_W    = 128,
   parameter int WORD_W   = 16,
   parameter int RD_REG   = 0,
   localparam int WORDS    = BUF_W / WORD_W,
   localparam int ADDR_W   = $clog2(WORDS),
   localparam int IDX_W    = $clog2(BUF_W),
   localparam int HALF_MIN = (SYS_HZ + 2 * RATE_MAX - 1) / (2 * RATE_MAX),
   localparam int HALF_MAX = SYS_HZ / (2 * RATE_MIN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DIV_W-1:0]  div_half,
   input  logic [CNT_W-1:0]  frame_bits,
   input  logic              rb_data,
   output logic              rb_clk,
   output logic              busy,
   output logic              done,
   output logic              cfg_err,
   output logic [NBUF-1:0]   full,
   output logic              overrun,
   input  logic [NBUF-1:0]   ack,
   input  logic              rd_sel,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data
);
   if (BUF_W % WORD_W != 0) begin : g_bad_word
      $error("BUF_W must be a multiple of WORD_W");
   end
   if ((1 << ADDR_W) != WORDS) begin : g_bad_words
      $error("BUF_W / WORD_W must be a power of two");
   end
   if (HALF_MIN < 1 || HALF_MIN > HALF_MAX) begin : g_bad_window
      $error("bit rate window is empty at this system clock");
   end
   if (HALF_MAX >= (1 << DIV_W)) begin : g_bad_div
      $error("DIV_W too narrow for the slowest legal bit rate");
   end

   logic             sample;
   logic [DIV_W-1:0] half_q;
   logic             wr_en, wr_sel;
   logic [IDX_W-1:0] wr_idx;

   rbk_ctrl #(
      .DIV_W(DIV_W), .CNT_W(CNT_W), .BUF_W(BUF_W),
      .HALF_MIN(HALF_MIN), .HALF_MAX(HALF_MAX)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .div_half(div_half),
      .frame_bits(frame_bits), .sample(sample), .ack(ack), .busy(busy),
      .half_q(half_q), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
      .done(done), .cfg_err(cfg_err), .full(full), .overrun(overrun)
   );

   rbk_bitclk #(.DIV_W(DIV_W)) u_bitclk (
      .clk(clk), .rst_n(rst_n), .run(busy), .half(half_q),
      .rb_clk(rb_clk), .sample(sample)
   );

   rbk_bank #(.BUF_W(BUF_W), .WORD_W(WORD_W), .RD_REG(RD_REG)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_idx(wr_idx), .wr_bit(rb_data), .rd_sel(rd_sel),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );
endmodule

// File: tb/rb_pingpong_capture_tb.sv
module rb_pingpong_capture_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  div_half = 8'd25;
   logic [31:0] frame_bits = 32'd1;
   logic        rb_data = 1'b0;
   logic        rb_clk, busy, done, cfg_err, overrun;
   logic [1:0]  full;
   logic [1:0]  ack = 2'b00;
   logic        rd_sel = 1'b0;
   logic [2:0]  rd_addr = 3'd0;
   logic [15:0] rd_data;

   int n_chk = 0;
   int n_fail = 0;
   int bidx = 0;
   int frame_n = 0;
   int done_seen = 0;

   always #5 clk = ~clk;

   rb_pingpong_capture u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .div_half(div_half),
      .frame_bits(frame_bits), .rb_data(rb_data), .rb_clk(rb_clk),
      .busy(busy), .done(done), .cfg_err(cfg_err), .full(full),
      .overrun(overrun), .ack(ack), .rd_sel(rd_sel), .rd_addr(rd_addr),
      .rd_data(rd_data)
   );

   function automatic logic pat_bit(input int k);
      logic [31:0] t;
      t = 32'(k) * 32'h61C8_8647;
      return ^t[31:16];
   endfunction

   function automatic logic [15:0] exp_word(input int fill, input int w, input int n);
      logic [15:0] v;
      for (int j = 0; j < 16; j++) begin
         int k;
         k = fill * 128 + w * 16 + j;
         v[j] = (k < n) ? pat_bit(k) : 1'b0;
      end
      return v;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // serial source: next bit one system clock after rb_clk falls
   always begin
      @(negedge rb_clk);
      @(negedge clk);
      bidx++;
      rb_data = pat_bit(bidx);
   end

   always @(negedge clk) if (done) done_seen++;

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL R7 watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   task automatic do_start(input int d, input int n);
      @(negedge clk);
      div_half = 8'(d);
      frame_bits = 32'(n);
      if (!busy) begin
         bidx = 0;
         rb_data = pat_bit(0);
         frame_n = n;
         done_seen = 0;
      end
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic measure_period(output int p);
      int c;
      c = 0;
      while (rb_clk !== 1'b0) @(negedge clk);
      while (rb_clk !== 1'b1) @(negedge clk);
      do begin
         @(negedge clk);
         c++;
      end while (!(rb_clk === 1'b1 && c > 1 && u_prev == 1'b0));
      p = c;
   endtask

   logic u_prev = 1'b0;
   always @(negedge clk) u_prev <= rb_clk;

   task automatic wait_full(input int b);
      int c;
      c = 0;
      while (full[b] !== 1'b1 && c < 20000) begin
         @(negedge clk);
         c++;
      end
   endtask

   task automatic wait_idle();
      int c;
      c = 0;
      while (busy === 1'b1 && c < 30000) begin
         @(negedge clk);
         c++;
      end
      @(negedge clk);
   endtask

   task automatic check_buf(input int b, input int fill, input int n, input string req);
      for (int w = 0; w < 8; w++) begin
         rd_sel = 1'(b);
         rd_addr = 3'(w);
         #1;
         chk(req, 32'(rd_data), 32'(exp_word(fill, w, n)));
      end
   endtask

   task automatic pulse_ack(input logic [1:0] a);
      @(negedge clk);
      ack = a;
      @(negedge clk);
      ack = 2'b00;
   endtask

   initial begin
      int p;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy", 32'(busy), 0);
      chk("R1 rb_clk", 32'(rb_clk), 0);
      chk("R1 flags", {27'd0, done, cfg_err, overrun, full}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 flags after release", {27'd0, busy, done, cfg_err, overrun, full}, 0);
      check_buf(0, 99, 0, "R1 buf0 zero");
      check_buf(1, 99, 0, "R1 buf1 zero");

      // R2 refused dividers
      for (int d = 0; d < 256; d++) begin
         if (d < 25 || d > 50) begin
            do_start(d, 10);
            chk("R2 refused busy", 32'(busy), 0);
            chk("R2 refused cfg_err", 32'(cfg_err), 1);
            chk("R4 idle rb_clk", 32'(rb_clk), 0);
         end
      end
      do_start(30, 0);
      chk("R2 zero frame busy", 32'(busy), 0);
      chk("R2 zero frame cfg_err", 32'(cfg_err), 1);

      // R2/R3/R7 legal divider sweep, two-bit frames
      for (int d = 25; d <= 50; d++) begin
         do_start(d, 2);
         chk("R2 accepted busy", 32'(busy), 1);
         chk("R2 accepted cfg_err", 32'(cfg_err), 0);
         measure_period(p);
         chk("R3 period", 32'(p), 32'(2 * d));
         wait_idle();
         chk("R7 done once", 32'(done_seen), 1);
         chk("R7 partial full", 32'(full), 32'b01);
         chk("R4 idle low", 32'(rb_clk), 0);
         rd_sel = 1'b0;
         rd_addr = 3'd0;
         #1;
         chk("R7 partial word", 32'(rd_data), 32'(exp_word(0, 0, 2)));
      end

      // main pass: 3 full buffers plus 40 bits
      do_start(25, 424);
      chk("R2 main busy", 32'(busy), 1);
      do_start(50, 7);   // ignored while busy, new divider not latched
      chk("R2 start while busy cfg_err", 32'(cfg_err), 0);
      measure_period(p);
      chk("R3 latched period", 32'(p), 50);
      for (int m = 0; m < 4; m++) begin
         wait_full(m % 2);
         @(negedge clk);
         chk("R5 full set", 32'(full[m % 2]), 1);
         check_buf(m % 2, m, 424, (m == 3) ? "R7 final partial buffer" : "R8 buffer content");
         if (m < 3) begin
            pulse_ack(2'b01 << (m % 2));
            chk("R6 ack clears", 32'(full[m % 2]), 0);
         end
      end
      wait_idle();
      chk("R7 main done once", 32'(done_seen), 1);
      chk("R7 main busy low", 32'(busy), 0);
      chk("R6 no overrun when acked", 32'(overrun), 0);

      // overrun pass: 3 full buffers, no acknowledge
      do_start(25, 384);
      wait_full(0);
      @(negedge clk);
      chk("R6 no overrun first fill", 32'(overrun), 0);
      wait_full(1);
      @(negedge clk);
      chk("R6 no overrun second fill", 32'(overrun), 0);
      wait_idle();
      chk("R6 overrun set", 32'(overrun), 1);
      chk("R6 both full", 32'(full), 32'b11);
      check_buf(0, 2, 384, "R6 overwritten buf0");
      check_buf(1, 1, 384, "R5 buf1 second chunk");
      do_start(40, 1);
      chk("R6 overrun cleared by start", 32'(overrun), 0);
      wait_idle();
      chk("R7 single bit done", 32'(done_seen), 1);
      check_buf(0, 0, 1, "R7 single bit buffer");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule